// File: doc/BRIEF.md
# Video Receiver Configuration Register Slave (I2C)

This block is the control port of a three-channel analog video receiver. It acts as a two-wire (I2C) slave that holds byte-wide configuration registers: the general mode byte, the equalizer boost codes, the output noise-filter code, three per-channel gain codes, three per-channel offset bytes and a calibration control byte. All writable registers go out on one flat bus to the analog controls. A separate calibration-start line goes to the offset calibration controller, which pulses a completion strobe to clear that command bit.

The serial lines first pass through a synchronizer and a level filter. A level must hold for a set number of system clocks before the block accepts it, so short spikes are removed. A transaction with a write direction loads an internal byte pointer from its first data byte. Each later data byte goes to the register the pointer selects, and the pointer then advances. To read, the master sets the pointer, issues a repeated start and addresses the device with the read direction. Bytes then stream out from the pointer, which advances after each byte, until the master answers with a NACK. Two address pins supply the low two bits of the 7-bit slave address, so four such receivers can share a bus.

Top module: `vid_cfg_i2c_slave`

## Requirements
- R1: The slave address is 7'b10001 followed by addr_sel[1] and then addr_sel[0]. The block pulls SDA low in the acknowledge slot only when the address byte's upper seven bits match. A mismatched transaction leaves every register unchanged.
- R2: After reset, cfg_bus byte k-1 holds register k. Register 0x01 resets to 0x02, registers 0x06 to 0x08 reset to 0x40, and all other writable registers (0x02 to 0x05 and 0x09 to 0x0C) reset to 0x00. sda_oe and cal_start are 0.
- R3: Register 0x00 always reads {DEV_ID, DEV_REV}, which is 0x10 with the default parameters. Writes to it change nothing.
- R4: In a write transaction, the first data byte loads the pointer. Each later byte is stored at the pointer, after which the pointer increments. A burst of three data bytes after the pointer fills three consecutive registers. Registers change only on such a write or on the calibration clear.
- R5: After a repeated start with R/W=1, each returned byte (MSB first) comes from the pointer, and the pointer increments after each byte. The block leaves SDA released during the master's acknowledge bit. A NACK (SDA high) ends the burst, and SDA then stays released until the next start.
- R6: Addresses 0x0D and above read as 0x00, and writes to them are discarded.
- R7: Bit 0 of register 0x0C drives cal_start. A one-cycle cal_done pulse clears that bit and leaves bits 7:1 as they were. A write to 0x0C in the same cycle takes priority over the clear.
- R8: Before the first start condition, SCL and SDA activity is ignored. The block never drives SDA and stores nothing.
- R9: A level on SCL or SDA that lasts fewer than FILT_CYC system clocks (default 6) is rejected and does not disturb a transfer.
- R10: The block starts pulling SDA low only while SCL is low, after a filtered SCL falling edge. It releases SDA at a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| addr_sel | input | 2 | Low two bits of the slave address (strap pins) |
| cal_done | input | 1 | One-cycle strobe from the calibration controller: clears the start bit |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cal_start | output | 1 | Calibration command bit (register 0x0C bit 0) |
| cfg_bus | output | 96 | Registers 0x01..0x0C, register k in bits 8k-1:8k-8 |

## Verification
The bound checker watches four things on every cycle. It confirms the reset values on the cycle reset ends and that the register bus moves only after a write or a calibration clear. It also checks that the completion strobe clears the start bit, and that SDA is never first pulled low while filtered SCL is high and is always released after a stop. The following can only be shown by complete bus scenarios in the bench: address matching against the strap pins, pointer loading and auto-increment over bursts, the read-only identity byte, unimplemented addresses, NACK ending a read, activity before any start, and spikes shorter than the filter window.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  LAST_RW_REG = 8'h0C;
    localparam logic [7:0]  CAL_REG     = 8'h0C;
    localparam int          CAL_BIT     = 0;
    localparam int          NUM_RW      = int'(LAST_RW_REG);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic             en;
        logic [7:0]       addr;
        logic [7:0]       data;
    } reg_wr_t;

    // Reset value of register at address idx (1..NUM_RW)
    function automatic logic [7:0] reg_default(input int unsigned idx);
        if (idx == 1)
            return 8'h02;
        else if (idx >= 6 && idx <= 8)
            return 8'h40;
        else
            return 8'h00;
    endfunction

    function automatic logic [8*NUM_RW-1:0] all_defaults();
        logic [8*NUM_RW-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_RW; i++)
            v[8*i +: 8] = reg_default(i + 1);
        return v;
    endfunction

endpackage

// File: rtl/vcfg_deglitch.sv
module vcfg_deglitch #(
    parameter int   FILT_CYC = 6,
    parameter logic INIT     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= INIT;
            sync2 <= INIT;
            dout  <= INIT;
            cnt   <= '0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
            if (sync2 == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
                dout <= sync2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vcfg_bus_events.sv
module vcfg_bus_events
    import vcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/vcfg_i2c_engine.sv
module vcfg_i2c_engine
    import vcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       sda_f,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output reg_wr_t    wr,
    output logic       sda_oe
);
    bus_state_e  state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  ptr;
    logic        have_ptr;
    logic        rw;
    logic        nack;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            have_ptr <= 1'b0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            if (shreg[7:1] == dev_addr) begin
                                rw       <= shreg[0];
                                have_ptr <= 1'b0;
                                sda_oe   <= 1'b1;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall && bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                            if (!have_ptr) begin
                                ptr      <= shreg;
                                have_ptr <= 1'b1;
                            end else begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RD_ACK;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            nack <= sda_f;
                        end else if (evt.scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                state  <= ST_RD_BYTE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/vcfg_regfile.sv
module vcfg_regfile
    import vcfg_pkg::*;
#(
    parameter logic [3:0] DEV_ID  = 4'h1,
    parameter logic [3:0] DEV_REV = 4'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    input  logic [7:0]           rd_addr,
    input  logic                 cal_done,
    output logic [7:0]           rd_data,
    output logic [8*NUM_RW-1:0]  cfg_bus,
    output logic                 cal_start
);
    localparam int CAL_IDX = int'(CAL_REG) - 1;

    logic [7:0] regs [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        localparam logic IS_CAL = (g == CAL_IDX);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= reg_default(g + 1);
            end else if (wr.en && wr.addr == 8'(g + 1)) begin
                regs[g] <= wr.data;
            end else if (IS_CAL && cal_done) begin
                regs[g][CAL_BIT] <= 1'b0;
            end
        end
        assign cfg_bus[8*g +: 8] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 8'h00) begin
            rd_data = {DEV_ID, DEV_REV};
        end else begin
            for (int i = 0; i < NUM_RW; i++)
                if (rd_addr == 8'(i + 1))
                    rd_data = regs[i];
        end
    end

    assign cal_start = regs[CAL_IDX][CAL_BIT];
endmodule

// File: rtl/vid_cfg_i2c_slave.sv
module vid_cfg_i2c_slave
    import vcfg_pkg::*;
#(
    parameter int         FILT_CYC   = 6,
    parameter logic [4:0] ADDR_FIXED = 5'b10001,
    parameter logic [3:0] DEV_ID     = 4'h1,
    parameter logic [3:0] DEV_REV    = 4'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic [1:0]           addr_sel,
    input  logic                 cal_done,
    output logic                 sda_oe,
    output logic                 cal_start,
    output logic [8*NUM_RW-1:0]  cfg_bus
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;
    bus_evt_t          evt;
    reg_wr_t           wr;
    logic [7:0]        rd_addr, rd_data;
    logic [6:0]        dev_addr;

    assign raw_lines = {scl_in, sda_in};

    for (genvar i = 0; i < NLINES; i++) begin : g_filt
        vcfg_deglitch #(.FILT_CYC(FILT_CYC), .INIT(1'b1)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[i]),
            .dout (filt_lines[i])
        );
    end

    assign scl_f    = filt_lines[1];
    assign sda_f    = filt_lines[0];
    assign dev_addr = {ADDR_FIXED, addr_sel};

    vcfg_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    vcfg_i2c_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sda_f    (sda_f),
        .dev_addr (dev_addr),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr       (wr),
        .sda_oe   (sda_oe)
    );

    vcfg_regfile #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_addr   (rd_addr),
        .cal_done  (cal_done),
        .rd_data   (rd_data),
        .cfg_bus   (cfg_bus),
        .cal_start (cal_start)
    );
endmodule

// File: rtl/vcfg_checker.sv
module vcfg_checker
    import vcfg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                scl_f,
    input logic                sda_oe,
    input logic                evt_stop,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic                cal_done,
    input logic                cal_start,
    input logic [8*NUM_RW-1:0] cfg_bus
);
    localparam logic [8*NUM_RW-1:0] DEFAULTS = all_defaults();

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_bus == DEFAULTS && !sda_oe)) else $error("reset values"); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(cal_done)) |-> $stable(cfg_bus)) else $error("bus moved"); // R4

    AST_CAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cal_done && !(wr_en && wr_addr == CAL_REG)) |=> !cal_start) else $error("cal bit"); // R7

    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f) else $error("drive while high"); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        evt_stop |=> !sda_oe) else $error("held after stop"); // R10
endmodule

bind vid_cfg_i2c_slave vcfg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .evt_stop  (evt.stop),
    .wr_en     (wr.en),
    .wr_addr   (wr.addr),
    .cal_done  (cal_done),
    .cal_start (cal_start),
    .cfg_bus   (cfg_bus)
);

// File: tb/tb_vid_cfg_i2c_slave.sv
module tb_vid_cfg_i2c_slave;
    localparam int NREG = 12;
    localparam int Q    = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic [1:0]        addr_sel = 2'b00;
    logic              cal_done = 1'b0;
    logic              sda_oe;
    logic              cal_start;
    logic [8*NREG-1:0] cfg_bus;
    logic              sda_line;
    logic              glitch_on = 1'b0;
    logic              done = 1'b0;
    int                checks = 0;
    int                errors = 0;
    int                drive_viol = 0;
    logic              oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    vid_cfg_i2c_slave dut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .addr_sel  (addr_sel),
        .cal_done  (cal_done),
        .sda_oe    (sda_oe),
        .cal_start (cal_start),
        .cfg_bus   (cfg_bus)
    );

    // R10: SDA pull-down may only begin while the raw clock is low
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && scl_m) drive_viol++;
        oe_prev <= sda_oe;
    end

    // {pointer, data written, value expected on read-back}
    localparam logic [23:0] VEC [7] = '{
        {8'h01, 8'h5A, 8'h5A},   // R4 plain register
        {8'h00, 8'hFF, 8'h10},   // R3 identity byte is read-only
        {8'h20, 8'h77, 8'h00},   // R6 unimplemented
        {8'h0D, 8'h33, 8'h00},   // R6 first unimplemented address
        {8'h08, 8'h3C, 8'h3C},   // R4 last gain register
        {8'h05, 8'h0F, 8'h0F},   // R4 filter code
        {8'h0B, 8'h81, 8'h81}    // R4 offset register
    };

    function automatic logic [7:0] dflt(input int k);
        if (k == 1) return 8'h02;
        if (k >= 6 && k <= 8) return 8'h40;
        return 8'h00;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        if (glitch_on) begin
            wt(3); scl_m = 1'b1; wt(3); scl_m = 1'b0; wt(Q - 6);
        end else begin
            wt(Q);
        end
        scl_m = 1'b1;
        if (glitch_on) begin
            wt(4); sda_m = ~b; wt(3); sda_m = b; wt(2*Q - 7);
        end else begin
            wt(2*Q);
        end
        scl_m = 1'b0;
        wt(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1;
        wt(Q); scl_m = 1'b1; wt(Q);
        b = sda_line;
        wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic write_seq(input logic [6:0] a, input logic [7:0] p,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             input int n, output logic addr_ack);
        logic ack;
        bus_start;
        send_byte({a, 1'b0}, addr_ack);
        if (addr_ack) begin
            send_byte(p, ack);
            if (n > 0) send_byte(d0, ack);
            if (n > 1) send_byte(d1, ack);
            if (n > 2) send_byte(d2, ack);
        end
        bus_stop;
    endtask

    task automatic read_seq(input logic [6:0] a, input logic [7:0] p, input int n,
                            output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
        logic ack;
        logic [7:0] t;
        r0 = '0; r1 = '0; r2 = '0;
        bus_start;
        send_byte({a, 1'b0}, ack);
        send_byte(p, ack);
        bus_start;
        send_byte({a, 1'b1}, ack);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, t);
            if (i == 0) r0 = t;
            else if (i == 1) r1 = t;
            else r2 = t;
        end
        bus_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8*NREG-1:0] exp_bus;
        logic [7:0] r0, r1, r2, extra;
        logic a0, a1, a2, b;
        logic [6:0] dev;

        dev = 7'b1000100;
        wt(10);
        rst = 1'b0;
        wt(2);

        // R2: reset values on the bus
        for (int k = 1; k <= NREG; k++) exp_bus[8*(k-1) +: 8] = dflt(k);
        chk(cfg_bus == exp_bus, "R2 reset cfg_bus", cfg_bus, exp_bus);
        chk(!sda_oe && !cal_start, "R2 reset sda_oe/cal_start", {sda_oe, cal_start}, 0);

        // R8: activity with no start condition
        send_byte({dev, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h99, a2);
        bus_stop;
        chk(!a0 && !a1 && !a2, "R8 no ack before start", {a0, a1, a2}, 0);
        chk(cfg_bus[7:0] == 8'h02, "R8 reg1 untouched", cfg_bus[7:0], 8'h02);

        // R3: identity byte
        read_seq(dev, 8'h00, 1, r0, r1, r2);
        chk(r0 == 8'h10, "R3 identity read", r0, 8'h10);

        // Vector table: write then read back
        for (int v = 0; v < 7; v++) begin
            write_seq(dev, VEC[v][23:16], VEC[v][15:8], 8'h00, 8'h00, 1, a0);
            chk(a0, "R1 address ack", a0, 1);
            read_seq(dev, VEC[v][23:16], 1, r0, r1, r2);
            chk(r0 == VEC[v][7:0], "R4/R3/R6 vector read-back", r0, VEC[v][7:0]);
        end
        chk(cfg_bus[8*4 +: 8] == 8'h0F, "R4 reg5 on bus", cfg_bus[8*4 +: 8], 8'h0F);

        // R4/R5: burst write and burst read over the gain registers
        write_seq(dev, 8'h06, 8'h11, 8'h22, 8'h33, 3, a0);
        chk(cfg_bus[8*5 +: 24] == 24'h332211, "R4 burst write auto-increment",
            cfg_bus[8*5 +: 24], 24'h332211);
        read_seq(dev, 8'h06, 3, r0, r1, r2);
        chk({r0, r1, r2} == 24'h112233, "R5 burst read auto-increment", {r0, r1, r2}, 24'h112233);

        // R5: NACK ends the burst; slave stays off the line (reg 0x02 is 0x00)
        bus_start;
        send_byte({dev, 1'b0}, a0);
        send_byte(8'h02, a0);
        bus_start;
        send_byte({dev, 1'b1}, a0);
        recv_byte(1'b1, r0);
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            extra[i] = b;
        end
        bus_stop;
        chk(r0 == 8'h00, "R5 byte before NACK", r0, 8'h00);
        chk(extra == 8'hFF, "R5 released after NACK", extra, 8'hFF);

        // R1: strap pins select the address
        addr_sel = 2'b10;
        write_seq(7'b1000100, 8'h01, 8'hEE, 8'h00, 8'h00, 1, a0);
        chk(!a0, "R1 old address not acked", a0, 0);
        write_seq(7'b1000101, 8'h01, 8'hEE, 8'h00, 8'h00, 1, a1);
        chk(!a1, "R1 wrong low bits not acked", a1, 0);
        read_seq(7'b1000110, 8'h01, 1, r0, r1, r2);
        chk(r0 == 8'h5A, "R1 mismatched writes discarded", r0, 8'h5A);
        addr_sel = 2'b00;

        // R7: calibration start bit clears on completion
        write_seq(dev, 8'h0C, 8'h07, 8'h00, 8'h00, 1, a0);
        chk(cal_start == 1'b1, "R7 cal_start set", cal_start, 1);
        cal_done = 1'b1; wt(1); cal_done = 1'b0; wt(2);
        chk(cal_start == 1'b0, "R7 cal_start cleared", cal_start, 0);
        read_seq(dev, 8'h0C, 1, r0, r1, r2);
        chk(r0 == 8'h06, "R7 other bits kept", r0, 8'h06);

        // R9: short spikes on both lines during a write
        glitch_on = 1'b1;
        write_seq(dev, 8'h04, 8'hA5, 8'h00, 8'h00, 1, a0);
        glitch_on = 1'b0;
        chk(a0, "R9 ack despite spikes", a0, 1);
        read_seq(dev, 8'h04, 1, r0, r1, r2);
        chk(r0 == 8'hA5, "R9 data intact under spikes", r0, 8'hA5);

        // R10: line released after stop, never first driven with SCL high
        chk(!sda_oe, "R10 released after stop", sda_oe, 0);
        chk(drive_viol == 0, "R10 drive starts only with SCL low", drive_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule